// File: doc/BRIEF.md
# Redundant Serial Keycode Uplink Receiver

This block takes a remote keypad command that arrives as a serial bit stream and collects it in a 16-bit shift register. A strobe marks each valid bit. The bit goes into the least-significant position and every bit already held moves up by one. A sender opens each word with a single 1 that acts as a frame marker. When that marker lands in the top bit, the block raises an interrupt request and stops taking bits.

A word carries the 5-bit keycode three times. The middle copy is sent inverted. The block removes the inversion and compares the three copies. It then reports either the keycode or a corruption error, together with the interrupt request. The consumer services the request and pulses `clear`, which zeroes the register so the next word can arrive. Bits that arrive while a finished word is waiting are dropped, and a sticky flag records that they arrived.

The control is a two-state machine:
- **GATHER** shifts bits in. It moves to **HOLD** on the strobe that would set the top bit. In GATHER, `clear` only zeroes the partial word.
- **HOLD** asserts the request and ignores strobes. It returns to **GATHER** on `clear`.

Top module: `uplink_key_rx`

## Requirements
- R1: After reset, `rx_word` is zero and `irq`, `keycode_valid`, `keycode_error` and `overrun` are all 0.
- R2: While no word is complete, each cycle with `bit_strobe` high and `clear` low loads `bit_in` into bit 0 and moves bits 14..0 up one place. Without a strobe the register holds.
- R3: `irq` goes high in the cycle after the strobe that makes bit 15 equal 1, and stays high until `clear`. Sending a word with its leading 1 first takes exactly 16 strobes.
- R4: Word layout: bit 15 is the marker 1, bits 14:10 are keycode K, bits 9:5 are the bitwise complement of K, bits 4:0 are K. When all three copies agree, `keycode_valid` is 1 and `keycode` equals K, together with `irq`.
- R5: When any copy disagrees (after undoing the inversion of bits 9:5), `keycode_error` is 1, `keycode_valid` is 0 and `keycode` is 0, together with `irq`.
- R6: `keycode`, `keycode_valid`, `keycode_error` and `rx_word` hold their values while `irq` is high. A `clear` zeroes `rx_word` and drops `irq`, `keycode_valid`, `keycode_error` and `overrun` in the next cycle.
- R7: While `irq` is high and `clear` is low, a strobe leaves `rx_word` unchanged and sets `overrun`. `overrun` then stays set until `clear`.
- R8: When `clear` and `bit_strobe` are high in the same cycle, the clear wins: `rx_word` becomes zero and the bit is lost, whether or not a word was complete.
- R9: A `clear` during an incomplete word discards the partial bits. `irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_strobe | input | 1 | Marks a valid serial bit this cycle |
| bit_in | input | 1 | Serial data bit |
| clear | input | 1 | Zeroes the receive register and ends service |
| rx_word | output | 16 | Receive shift register contents |
| irq | output | 1 | Completed word waiting for service |
| keycode | output | 5 | Decoded keycode; zero unless valid |
| keycode_valid | output | 1 | Copies agree |
| keycode_error | output | 1 | Copies disagree |
| overrun | output | 1 | Sticky: bits arrived while a word was waiting |

## Verification
Two of the block's functions can fall in the same cycle: the consumer's clear and the arrival of a new bit. The bench forces this coincidence twice:
- once halfway through a word, where the strobe would otherwise shift;
- once while a complete word waits and overrun is already set, where the strobe would otherwise keep overrun set.

In both cases it judges the next cycle. The register must read zero and the interrupt and overrun must be low, so the clear has won. The strobe-while-full case without a clear is checked separately, to show that the word is frozen and that overrun rises.

// File: rtl/uplink_key_pkg.sv
package uplink_key_pkg;
    typedef enum logic [0:0] {
        ST_GATHER = 1'b0,
        ST_HOLD   = 1'b1
    } rx_state_t;
endpackage

// File: rtl/uplink_shift_reg.sv
module uplink_shift_reg #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              zero_en,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (zero_en) begin
            word_q <= '0;
        end else if (shift_en) begin
            word_q <= {word_q[WORD_W-2:0], bit_in};
        end
    end
endmodule

// File: rtl/uplink_rx_ctrl.sv
module uplink_rx_ctrl
    import uplink_key_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_strobe,
    input  logic              clear,
    input  logic [WORD_W-1:0] word_q,
    output logic              shift_en,
    output logic              zero_en,
    output logic              irq,
    output logic              overrun
);
    rx_state_t state_q, state_d;
    logic      ovr_set;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_GATHER;
        end else begin
            state_q <= state_d;
        end
    end

    // sticky overrun flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (zero_en) begin
            overrun <= 1'b0;
        end else if (ovr_set) begin
            overrun <= 1'b1;
        end
    end

    // transitions and control strobes
    always_comb begin
        state_d  = state_q;
        shift_en = 1'b0;
        zero_en  = 1'b0;
        ovr_set  = 1'b0;
        unique case (state_q)
            ST_GATHER: begin
                if (clear) begin
                    zero_en = 1'b1;
                end else if (bit_strobe) begin
                    shift_en = 1'b1;
                    if (word_q[WORD_W-2]) begin
                        state_d = ST_HOLD;
                    end
                end
            end
            ST_HOLD: begin
                if (clear) begin
                    zero_en = 1'b1;
                    state_d = ST_GATHER;
                end else if (bit_strobe) begin
                    ovr_set = 1'b1;
                end
            end
            default: state_d = ST_GATHER;
        endcase
    end

    // outputs
    always_comb begin
        irq = (state_q == ST_HOLD);
    end
endmodule

// File: rtl/uplink_copy_vote.sv
module uplink_copy_vote #(
    parameter int KEY_W  = 5,
    parameter int COPIES = 3,
    localparam int WORD_W = 1 + KEY_W * COPIES
) (
    input  logic [WORD_W-1:0] word_q,
    input  logic              enable,
    output logic [KEY_W-1:0]  keycode,
    output logic              keycode_valid,
    output logic              keycode_error
);
    logic [COPIES-1:0][KEY_W-1:0] norm;
    logic [COPIES-1:0]            agree;
    logic                         all_agree;

    // copy 0 sits just below the marker; odd copies travel inverted
    for (genvar i = 0; i < COPIES; i++) begin : g_copy
        localparam int LO = KEY_W * (COPIES - 1 - i);
        if (i % 2 == 1) begin : g_inv
            assign norm[i] = ~word_q[LO +: KEY_W];
        end else begin : g_plain
            assign norm[i] = word_q[LO +: KEY_W];
        end
        assign agree[i] = (norm[i] == norm[0]);
    end

    assign all_agree     = &agree;
    assign keycode_valid = enable & all_agree;
    assign keycode_error = enable & ~all_agree;
    assign keycode       = keycode_valid ? norm[0] : '0;
endmodule

// File: rtl/uplink_key_rx.sv
module uplink_key_rx #(
    parameter int KEY_W  = 5,
    parameter int COPIES = 3,
    localparam int WORD_W = 1 + KEY_W * COPIES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_strobe,
    input  logic              bit_in,
    input  logic              clear,
    output logic [WORD_W-1:0] rx_word,
    output logic              irq,
    output logic [KEY_W-1:0]  keycode,
    output logic              keycode_valid,
    output logic              keycode_error,
    output logic              overrun
);
    logic shift_en;
    logic zero_en;

    uplink_shift_reg #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .zero_en  (zero_en),
        .shift_en (shift_en),
        .bit_in   (bit_in),
        .word_q   (rx_word)
    );

    uplink_rx_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_strobe (bit_strobe),
        .clear      (clear),
        .word_q     (rx_word),
        .shift_en   (shift_en),
        .zero_en    (zero_en),
        .irq        (irq),
        .overrun    (overrun)
    );

    uplink_copy_vote #(.KEY_W(KEY_W), .COPIES(COPIES)) u_vote (
        .word_q        (rx_word),
        .enable        (irq),
        .keycode       (keycode),
        .keycode_valid (keycode_valid),
        .keycode_error (keycode_error)
    );
endmodule

// File: rtl/uplink_key_rx_chk.sv
module uplink_key_rx_chk #(
    parameter int KEY_W  = 5,
    parameter int COPIES = 3,
    localparam int WORD_W = 1 + KEY_W * COPIES
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_strobe,
    input logic              bit_in,
    input logic              clear,
    input logic [WORD_W-1:0] rx_word,
    input logic              irq,
    input logic [KEY_W-1:0]  keycode,
    input logic              keycode_valid,
    input logic              keycode_error,
    input logic              overrun
);
    assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_strobe && !clear && !irq) |=>
            (rx_word == {$past(rx_word[WORD_W-2:0]), $past(bit_in)}));

    assert_irq_marker_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq == rx_word[WORD_W-1]);

    assert_verdict_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (keycode_valid || keycode_error) == irq && !(keycode_valid && keycode_error));

    assert_error_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
        keycode_error |-> (keycode == '0));

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (rx_word == '0 && !irq && !overrun));

    assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && bit_strobe && !clear) |=> ($stable(rx_word) && overrun));

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !clear) |=> overrun);

    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && bit_strobe) |=> (rx_word == '0));
endmodule

bind uplink_key_rx uplink_key_rx_chk #(.KEY_W(KEY_W), .COPIES(COPIES)) u_chk (.*);

// File: tb/uplink_key_rx_bench.sv
module uplink_key_rx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_strobe = 1'b0;
    logic        bit_in = 1'b0;
    logic        clear = 1'b0;
    logic [15:0] rx_word;
    logic        irq;
    logic [4:0]  keycode;
    logic        keycode_valid;
    logic        keycode_error;
    logic        overrun;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    uplink_key_rx u_uplink_key_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_strobe    (bit_strobe),
        .bit_in        (bit_in),
        .clear         (clear),
        .rx_word       (rx_word),
        .irq           (irq),
        .keycode       (keycode),
        .keycode_valid (keycode_valid),
        .keycode_error (keycode_error),
        .overrun       (overrun)
    );

    function automatic logic [15:0] make_word(input logic [4:0] k);
        return {1'b1, k, ~k, k};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // drive at negedge; the following posedge captures
    task automatic send_bit(input logic b);
        bit_strobe = 1'b1;
        bit_in     = b;
        @(negedge clk);
        bit_strobe = 1'b0;
        bit_in     = 1'b0;
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic do_clear();
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "rx_word", 32'(rx_word), 0);
        check("R1", "flags", {irq, keycode_valid, keycode_error, overrun}, 0);
    endtask

    task automatic t_shift_and_abort();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        check("R2", "partial word", 32'(rx_word), 32'h5);
        @(negedge clk); @(negedge clk);
        check("R2", "hold without strobe", 32'(rx_word), 32'h5);
        check("R9", "no irq mid-word", 32'(irq), 0);
        do_clear();
        check("R9", "partial discarded", 32'(rx_word), 0);
        check("R9", "irq after abort", 32'(irq), 0);
    endtask

    task automatic t_good_word(input logic [4:0] k);
        logic [15:0] w = make_word(k);
        for (int i = 15; i >= 1; i--) send_bit(w[i]);
        check("R3", "irq before last bit", 32'(irq), 0);
        send_bit(w[0]);
        check("R3", "irq after 16 bits", 32'(irq), 1);
        check("R4", "word", 32'(rx_word), 32'(w));
        check("R4", "valid", 32'({keycode_valid, keycode_error}), 32'h2);
        check("R4", "keycode", 32'(keycode), 32'(k));
        repeat (4) @(negedge clk);
        check("R6", "held", {irq, keycode_valid, 11'(keycode), rx_word}, {1'b1, 1'b1, 11'(k), w});
        do_clear();
        check("R6", "after clear", {rx_word, irq, keycode_valid, keycode_error}, 0);
    endtask

    task automatic t_bad_word(input logic [15:0] w);
        send_word(w);
        check("R5", "irq", 32'(irq), 1);
        check("R5", "error flags", 32'({keycode_valid, keycode_error}), 32'h1);
        check("R5", "keycode zero", 32'(keycode), 0);
        do_clear();
        check("R6", "error cleared", 32'(keycode_error), 0);
    endtask

    task automatic t_overrun();
        logic [15:0] w = make_word(5'h0A);
        send_word(w);
        send_bit(1'b0);
        send_bit(1'b1);
        check("R7", "word frozen", 32'(rx_word), 32'(w));
        check("R7", "overrun set", 32'(overrun), 1);
        repeat (3) @(negedge clk);
        check("R7", "overrun sticky", 32'(overrun), 1);
        check("R7", "still valid", 32'(keycode), 32'h0A);
        do_clear();
        check("R6", "overrun cleared", 32'(overrun), 0);
    endtask

    task automatic t_clear_priority();
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        clear = 1'b1; bit_strobe = 1'b1; bit_in = 1'b1;
        @(negedge clk);
        clear = 1'b0; bit_strobe = 1'b0; bit_in = 1'b0;
        check("R8", "mid-word clear wins", 32'(rx_word), 0);
        send_word(make_word(5'h11));
        send_bit(1'b1);
        check("R8", "overrun before", 32'(overrun), 1);
        clear = 1'b1; bit_strobe = 1'b1; bit_in = 1'b1;
        @(negedge clk);
        clear = 1'b0; bit_strobe = 1'b0; bit_in = 1'b0;
        check("R8", "full clear wins", {rx_word, irq, overrun}, 0);
    endtask

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_shift_and_abort();
        t_good_word(5'h15);
        t_good_word(5'h00);
        t_good_word(5'h1F);
        t_bad_word(16'hD5B5 ^ 16'h0020); // middle copy corrupted
        t_bad_word(make_word(5'h0C) ^ 16'h0001); // last copy corrupted
        t_bad_word(make_word(5'h07) ^ 16'h0400); // first copy corrupted
        t_overrun();
        t_clear_priority();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule